// File: doc/BRIEF.md
# LIN Wakeup and Bus Idle Timeout Supervisor

This block watches the timing side of a LIN node. It counts a prescaled time tick and follows the wakeup signals the node sends. It raises a sticky flag when no sync break answers a single wakeup, and another when a whole round of three wakeups goes unanswered. It also raises a sticky flag when the bus has shown no edge for the idle limit. Next to these it keeps a receiver-busy flag. That flag lets it refuse a power-down request while a frame is arriving and send a wakeup interrupt in its place.

The wakeup side is a four-state machine. `WK_REST` waits for a wakeup. `WK_ARMED` times one wakeup. `WK_GAP` waits for the next wakeup after a single timeout. `WK_ROUND` times the long wait after the third attempt.

The transitions are these. In `WK_REST`, a wakeup strobe leads to `WK_ARMED`. In `WK_ARMED`, the single timeout leads to `WK_GAP` when fewer than three attempts were made, and to `WK_ROUND` on the third. In `WK_GAP`, a wakeup strobe leads back to `WK_ARMED`. In `WK_ROUND`, the round timeout leads to `WK_REST`. A sync break, a soft reset or leaving LIN mode sends the machine to `WK_REST` from any state.

Top module: `lin_wake_supervisor`

## Requirements
- R1: After system reset the status word `stat` is 0. Its layout is: bit 7 is the three-wakeup timeout, bit 6 the single-wakeup timeout, bit 4 the bus idle timeout, bit 3 busy. Bits 5 and 2:0 always read 0.
- R2: In LIN mode, bit 6 sets on the WAKE1_TICKS-th tick after a wakeup strobe, provided no sync break comes in between. A new wakeup strobe while waiting restarts the wait.
- R3: When the third wakeup of a round has timed out, bit 7 sets after a further WAKE3_TICKS ticks with no sync break. The attempt count then returns to zero.
- R4: A sync break resets the attempt count and cancels any pending single or round timeout.
- R5: In LIN mode, bit 4 sets on the IDLE_TICKS-th tick with no change of `bus_level`. Any edge, rising or falling, restarts the count.
- R6: With `lin_mode` low, bits 7, 6 and 4 never set.
- R7: Each timeout flag clears on any of these: a `soft_rst` or `mod_rst` pulse, system reset, `clr_wr` with a 1 in its `clr_mask` bit, or `vec_rd` with `vec_sel` 1 (bit 6), 2 (bit 7) or 3 (bit 4). Mask zeros and other selector codes have no effect.
- R8: When a flag's set event and one of its clears fall in the same cycle, the flag ends up set.
- R9: Busy sets on `start_bit` and clears on `frame_done`, `soft_rst` or `mod_rst`, in either mode. A `clr_wr` write does not clear it.
- R10: `pd_grant` equals `pd_req` except when `wake_int_en` and busy are both high. In that case `pd_grant` is 0 and `wake_irq` is 1 during the request. `wake_irq` is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| lin_mode | input | 1 | 1 = LIN mode, 0 = plain SCI mode |
| tick | input | 1 | One-cycle time tick (1 ms by default) |
| bus_level | input | 1 | Sampled bus level (1 = recessive) |
| sync_break | input | 1 | Sync break detected strobe |
| start_bit | input | 1 | Receiver saw start of a start bit |
| frame_done | input | 1 | Receiver finished a frame |
| wake_sent | input | 1 | Node sent a wakeup signal |
| soft_rst | input | 1 | Software reset pulse |
| mod_rst | input | 1 | Module reset pulse |
| clr_wr | input | 1 | Write-1-to-clear strobe |
| clr_mask | input | 8 | Write data, laid out like `stat` |
| vec_rd | input | 1 | Interrupt vector read strobe |
| vec_sel | input | 2 | Vector read: 1 single, 2 round, 3 idle |
| wake_int_en | input | 1 | Wakeup interrupt enable |
| pd_req | input | 1 | Power-down request |
| pd_grant | output | 1 | Power-down allowed |
| wake_irq | output | 1 | Wakeup interrupt (power-down refused) |
| stat | output | 8 | Status word |

## Verification
The bench builds the block with WAKE1_TICKS=4, WAKE3_TICKS=6 and IDLE_TICKS=8. At these sizes every tick count from zero up to one past each limit can be swept, and each expected flag is computed as count >= limit. The full three-wakeup round also fits in a few dozen cycles. The same holds for restarting the idle count one tick before it expires and for a set that lands in the same cycle as a clear.

// File: rtl/lin_sup_pkg.sv
package lin_sup_pkg;
    typedef enum logic [1:0] {
        WK_REST  = 2'd0,
        WK_ARMED = 2'd1,
        WK_GAP   = 2'd2,
        WK_ROUND = 2'd3
    } wk_state_t;

    localparam int BIT_ROUND = 7;
    localparam int BIT_ONE   = 6;
    localparam int BIT_IDLE  = 4;
    localparam int BIT_BUSY  = 3;
    localparam int MAX_TRIES = 3;
endpackage

// File: rtl/lin_sticky_flag.sv
module lin_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr_ev,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag <= 1'b0;
        else if (set_ev) flag <= 1'b1;
        else if (clr_ev) flag <= 1'b0;
    end

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev |=> flag);
endmodule

// File: rtl/lin_wake_fsm.sv
module lin_wake_fsm
    import lin_sup_pkg::*;
#(
    parameter int WAKE1_TICKS = 150,
    parameter int WAKE3_TICKS = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_clr,
    input  logic lin_mode,
    input  logic tick,
    input  logic sync_break,
    input  logic wake_sent,
    output logic fire_one,
    output logic fire_round
);
    localparam int LIM_MAX = (WAKE1_TICKS > WAKE3_TICKS) ? WAKE1_TICKS : WAKE3_TICKS;
    localparam int CW      = $clog2(LIM_MAX + 1);
    localparam logic [CW-1:0] L1 = CW'(WAKE1_TICKS - 1);
    localparam logic [CW-1:0] L3 = CW'(WAKE3_TICKS - 1);

    wk_state_t     state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic [1:0]    tries_q, tries_n;
    logic [1:0]    tries_inc;

    assign tries_inc = (tries_q < 2'(MAX_TRIES)) ? tries_q + 2'd1 : tries_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WK_REST;
            cnt_q   <= '0;
            tries_q <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            tries_q <= tries_n;
        end
    end

    always_comb begin
        state_n    = state_q;
        cnt_n      = cnt_q;
        tries_n    = tries_q;
        fire_one   = 1'b0;
        fire_round = 1'b0;
        if (soft_clr || !lin_mode || sync_break) begin
            state_n = WK_REST;
            cnt_n   = '0;
            tries_n = '0;
        end else begin
            unique case (state_q)
                WK_REST: if (wake_sent) begin
                    state_n = WK_ARMED;
                    cnt_n   = '0;
                    tries_n = 2'd1;
                end
                WK_ARMED: begin
                    if (wake_sent) begin
                        cnt_n   = '0;
                        tries_n = tries_inc;
                    end else if (tick) begin
                        if (cnt_q == L1) begin
                            fire_one = 1'b1;
                            cnt_n    = '0;
                            state_n  = (tries_q >= 2'(MAX_TRIES)) ? WK_ROUND : WK_GAP;
                        end else begin
                            cnt_n = cnt_q + 1'b1;
                        end
                    end
                end
                WK_GAP: if (wake_sent) begin
                    state_n = WK_ARMED;
                    cnt_n   = '0;
                    tries_n = tries_inc;
                end
                WK_ROUND: if (tick) begin
                    if (cnt_q == L3) begin
                        fire_round = 1'b1;
                        state_n    = WK_REST;
                        cnt_n      = '0;
                        tries_n    = '0;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                default: state_n = WK_REST;
            endcase
        end
    end

    // R3
    round_after_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_round |-> tries_q == 2'(MAX_TRIES));

    // R4
    break_cancels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sync_break) |-> !fire_round);
endmodule

// File: rtl/lin_idle_timer.sv
module lin_idle_timer #(
    parameter int IDLE_TICKS = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_clr,
    input  logic lin_mode,
    input  logic tick,
    input  logic bus_level,
    output logic fire_idle
);
    localparam int CW = $clog2(IDLE_TICKS + 1);
    localparam logic [CW-1:0] LIM = CW'(IDLE_TICKS);

    logic          prev_q;
    logic          bus_edge;
    logic [CW-1:0] cnt_q;

    assign bus_edge  = bus_level ^ prev_q;
    assign fire_idle = lin_mode && tick && (cnt_q == LIM - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            cnt_q  <= '0;
        end else begin
            prev_q <= bus_level;
            if (soft_clr || !lin_mode || bus_edge) cnt_q <= '0;
            else if (tick && cnt_q < LIM)          cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5
    edge_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_edge) && IDLE_TICKS > 1 |-> !fire_idle);
endmodule

// File: rtl/lin_wake_supervisor.sv
module lin_wake_supervisor
    import lin_sup_pkg::*;
#(
    parameter int WAKE1_TICKS = 150,
    parameter int WAKE3_TICKS = 1500,
    parameter int IDLE_TICKS  = 4000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lin_mode,
    input  logic       tick,
    input  logic       bus_level,
    input  logic       sync_break,
    input  logic       start_bit,
    input  logic       frame_done,
    input  logic       wake_sent,
    input  logic       soft_rst,
    input  logic       mod_rst,
    input  logic       clr_wr,
    input  logic [7:0] clr_mask,
    input  logic       vec_rd,
    input  logic [1:0] vec_sel,
    input  logic       wake_int_en,
    input  logic       pd_req,
    output logic       pd_grant,
    output logic       wake_irq,
    output logic [7:0] stat
);
    localparam int NFLAG = 3;
    localparam int FBIT [NFLAG] = '{BIT_ONE, BIT_ROUND, BIT_IDLE};

    logic             soft_clr;
    logic             fire_one, fire_round, fire_idle;
    logic [NFLAG-1:0] set_v, clr_v, flag_v;
    logic             busy;

    assign soft_clr = soft_rst | mod_rst;
    assign set_v    = {fire_idle, fire_round, fire_one};

    lin_wake_fsm #(.WAKE1_TICKS(WAKE1_TICKS), .WAKE3_TICKS(WAKE3_TICKS)) u_wake (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .lin_mode(lin_mode),
        .tick(tick), .sync_break(sync_break), .wake_sent(wake_sent),
        .fire_one(fire_one), .fire_round(fire_round)
    );

    lin_idle_timer #(.IDLE_TICKS(IDLE_TICKS)) u_idle (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .lin_mode(lin_mode),
        .tick(tick), .bus_level(bus_level), .fire_idle(fire_idle)
    );

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        assign clr_v[i] = soft_clr
                        | (clr_wr && clr_mask[FBIT[i]])
                        | (vec_rd && vec_sel == 2'(i + 1));
        lin_sticky_flag u_flag (
            .clk(clk), .rst_n(rst_n), .set_ev(set_v[i]),
            .clr_ev(clr_v[i]), .flag(flag_v[i])
        );
    end

    lin_sticky_flag u_busy (
        .clk(clk), .rst_n(rst_n), .set_ev(start_bit),
        .clr_ev(frame_done | soft_clr), .flag(busy)
    );

    always_comb begin
        stat            = '0;
        stat[BIT_ONE]   = flag_v[0];
        stat[BIT_ROUND] = flag_v[1];
        stat[BIT_IDLE]  = flag_v[2];
        stat[BIT_BUSY]  = busy;
    end

    assign wake_irq = pd_req & wake_int_en & busy;
    assign pd_grant = pd_req & ~wake_irq;

    // R6
    sci_no_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[BIT_ONE]) |-> $past(lin_mode));
    // R6
    sci_no_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[BIT_IDLE]) |-> $past(lin_mode));
    // R7
    sticky_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat[BIT_ONE] && !clr_v[0] |=> stat[BIT_ONE]);
    // R9
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_bit |=> stat[BIT_BUSY]);
    // R10
    veto_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pd_grant && wake_irq));
    // R1
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat[5] == 1'b0 && stat[2:0] == 3'b000);
endmodule

// File: tb/lin_wake_supervisor_test.sv
module lin_wake_supervisor_test;
    localparam int W1 = 4;
    localparam int W3 = 6;
    localparam int WI = 8;

    logic clk = 0, rst_n = 0;
    logic lin_mode = 1, tick = 0, bus_level = 1, sync_break = 0;
    logic start_bit = 0, frame_done = 0, wake_sent = 0;
    logic soft_rst = 0, mod_rst = 0, clr_wr = 0, vec_rd = 0;
    logic [7:0] clr_mask = 0;
    logic [1:0] vec_sel = 0;
    logic wake_int_en = 0, pd_req = 0;
    logic pd_grant, wake_irq;
    logic [7:0] stat;
    int errors = 0, checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lin_wake_supervisor #(.WAKE1_TICKS(W1), .WAKE3_TICKS(W3), .IDLE_TICKS(WI)) uut (
        .clk(clk), .rst_n(rst_n), .lin_mode(lin_mode), .tick(tick),
        .bus_level(bus_level), .sync_break(sync_break), .start_bit(start_bit),
        .frame_done(frame_done), .wake_sent(wake_sent), .soft_rst(soft_rst),
        .mod_rst(mod_rst), .clr_wr(clr_wr), .clr_mask(clr_mask), .vec_rd(vec_rd),
        .vec_sel(vec_sel), .wake_int_en(wake_int_en), .pd_req(pd_req),
        .pd_grant(pd_grant), .wake_irq(wake_irq), .stat(stat)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
        tick = 0; sync_break = 0; start_bit = 0; frame_done = 0; wake_sent = 0;
        soft_rst = 0; mod_rst = 0; clr_wr = 0; clr_mask = 0; vec_rd = 0; vec_sel = 0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin tick = 1; nxt(); end
    endtask

    task automatic sreset();
        soft_rst = 1; nxt();
    endtask

    task automatic wake();
        wake_sent = 1; nxt();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        nxt();
        chk("R1 reset status", stat, 0);
        chk("R10 idle grant", pd_grant, 0);

        // R2 sweep of single-wakeup tick count
        for (int k = 0; k <= W1 + 1; k++) begin
            sreset(); wake(); ticks(k);
            chk("R2 single timeout", stat[6], k >= W1);
        end
        // R2 restart by a new wakeup
        sreset(); wake(); ticks(W1 - 1); wake(); ticks(W1 - 1);
        chk("R2 restart", stat[6], 0);
        ticks(1);
        chk("R2 after restart", stat[6], 1);

        // R3 sweep of round wait
        for (int m = 0; m <= W3 + 1; m++) begin
            sreset();
            for (int a = 0; a < 3; a++) begin wake(); ticks(W1); end
            ticks(m);
            chk("R3 round timeout", stat[7], m >= W3);
        end
        // R3 count returns to zero: a fresh wakeup is single only
        clr_wr = 1; clr_mask = 8'hC0; nxt();
        wake(); ticks(W1 + W3);
        chk("R3 count cleared", stat[7], 0);

        // R4 break resets attempt count
        sreset();
        for (int a = 0; a < 2; a++) begin wake(); ticks(W1); end
        sync_break = 1; nxt();
        wake(); ticks(W1 + W3);
        chk("R4 tries reset", stat[7], 0);
        // R4 break cancels a pending single timeout
        sreset(); wake(); ticks(W1 - 1); sync_break = 1; nxt(); ticks(W1);
        chk("R4 single cancelled", stat[6], 0);

        // R5 idle sweep
        for (int k = 0; k <= WI + 1; k++) begin
            sreset(); ticks(k);
            chk("R5 idle timeout", stat[4], k >= WI);
        end
        for (int dir = 0; dir < 2; dir++) begin
            sreset(); bus_level = dir[0]; ticks(WI - 1);
            bus_level = ~bus_level; nxt(); ticks(WI - 1);
            chk("R5 edge restart", stat[4], 0);
            ticks(1);
            chk("R5 after edge", stat[4], 1);
        end

        // R6 SCI mode
        sreset(); lin_mode = 0; nxt();
        for (int a = 0; a < 3; a++) begin wake(); ticks(W1); end
        ticks(WI + W3);
        chk("R6 sci flags", stat & 8'hD0, 0);
        lin_mode = 1; nxt();

        // R7 clear sources
        sreset(); wake(); ticks(W1);
        clr_wr = 1; clr_mask = 8'h00; nxt();
        chk("R7 write zero", stat[6], 1);
        clr_wr = 1; clr_mask = 8'h90; nxt();
        chk("R7 other mask", stat[6], 1);
        vec_rd = 1; vec_sel = 2; nxt();
        chk("R7 wrong vector", stat[6], 1);
        vec_rd = 1; vec_sel = 1; nxt();
        chk("R7 vector clear", stat[6], 0);
        sreset(); ticks(WI);
        vec_rd = 1; vec_sel = 3; nxt();
        chk("R7 idle vector", stat[4], 0);
        wake(); ticks(W1);
        clr_wr = 1; clr_mask = 8'h40; nxt();
        chk("R7 write one", stat[6], 0);
        wake(); ticks(W1); mod_rst = 1; nxt();
        chk("R7 module reset", stat[6], 0);

        // R8 set and clear together
        sreset(); wake(); ticks(W1 - 1);
        tick = 1; clr_wr = 1; clr_mask = 8'h40; nxt();
        chk("R8 set wins", stat[6], 1);

        // R9 busy
        for (int md = 0; md < 2; md++) begin
            lin_mode = md[0];
            start_bit = 1; nxt();
            chk("R9 busy set", stat[3], 1);
            clr_wr = 1; clr_mask = 8'hFF; nxt();
            chk("R9 write ignored", stat[3], 1);
            frame_done = 1; nxt();
            chk("R9 busy done", stat[3], 0);
        end
        lin_mode = 1;
        start_bit = 1; nxt(); soft_rst = 1; nxt();
        chk("R9 soft reset", stat[3], 0);

        // R10 power-down veto, all input combinations
        for (int c = 0; c < 8; c++) begin
            sreset();
            if (c[0]) begin start_bit = 1; nxt(); end
            wake_int_en = c[1]; pd_req = c[2]; #1;
            chk("R10 grant", pd_grant, c[2] && !(c[0] && c[1]));
            chk("R10 irq", wake_irq, c[0] && c[1] && c[2]);
            nxt(); wake_int_en = 0; pd_req = 0;
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule